// File: doc/BRIEF.md
# Wormhole Output Allocator

This block is the locking and forwarding core of a small packet switch that uses wormhole flow control. Several input ports each offer one flit per cycle under a valid/ready handshake. Every flit carries a two-bit kind, a last marker, a destination output index and a data word. A head flit asks for one output. If that output is free and the head wins arbitration, the flit goes straight through in the same cycle, and the output stays tied to that input. The body flits that follow use the held output without naming it again. The tail flit ends the message and frees the output.

An input whose output is held by another input, or that loses arbitration, gets ready low and keeps its flit in place until the output frees. Heads that reach the same free output together are settled by a round-robin pointer, one per output. The pointer moves only when a message ends, so a message is never interleaved with another one. Flits that break the ownership rules are consumed without being forwarded, and the block flags the input that sent them. Route computation, virtual channels and packet buffering belong to the blocks around this one.

Top module: `flit_lock_switch`

## Requirements
- R1: Kind codes are 00 idle, 01 head, 10 body, 11 tail. A head flit whose destination output is free and that wins arbitration appears on that output in the same cycle, with unchanged kind, last marker and data, on the output named by its destination field.
- R2: A head without the last marker that is accepted binds its output to its input. Until that input's tail is accepted, the output carries only body and tail flits from that input, in the order sent. An input holds at most one output at a time.
- R3: When a tail is accepted, its output is free from the next cycle, and a waiting head can take it in that cycle.
- R4: A head with the last marker set is a complete message. It passes through without binding the output.
- R5: A head toward an output that another input holds, or that lost arbitration this cycle, sees in_ready low and is held in place. No flit is lost.
- R6: Among heads that request the same free output in one cycle, the winner is the first requesting input at or after that output's pointer, counting upward and wrapping. The pointer resets to 0. It moves to one past an input when that input's message ends (its tail is accepted, or its single-flit head is accepted), not when the head is granted.
- R7: A body or tail from the owning input sees in_ready equal to the out_ready of the output it holds. While out_ready is low, nothing is taken from that input.
- R8: Two cases are protocol errors: a body or tail from an input that holds no output, and a head from an input that already holds one. The flit is accepted (in_ready high) but not forwarded, and proto_err for that input is high for exactly the next cycle.
- R9: After reset every output is free, out_valid is all zero and proto_err is all zero.
- R10: Different outputs work independently. Heads from different inputs to different free outputs both pass in the same cycle.
- R11: A valid flit of kind idle is accepted and has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | Flit valid, one bit per input |
| in_type | input | 2*N_IN | Flit kind per input (00 idle, 01 head, 10 body, 11 tail) |
| in_last | input | N_IN | Last marker on a head: single-flit message |
| in_dest | input | N_IN*DEST_W | Requested output index, used on head flits |
| in_data | input | N_IN*DATA_W | Flit payload per input |
| in_ready | output | N_IN | Flit accepted this cycle when valid is high |
| out_valid | output | N_OUT | Flit present on each output |
| out_type | output | 2*N_OUT | Flit kind per output |
| out_last | output | N_OUT | Last marker per output |
| out_data | output | N_OUT*DATA_W | Payload per output |
| out_ready | input | N_OUT | Downstream ready per output |
| proto_err | output | N_IN | One-cycle flag for an ownership violation by an input |

## Verification
The bench first targets the exact cycle in which an output changes hands. A design that frees the output one cycle late fails the tail-to-head check. A design that frees it on the last body flit lets another head slip in between. Overlapping multi-flit messages sent from all inputs to shared outputs expose any interleaving or reordering, because every flit carries its source and a sequence number. A pointer that moves at grant time instead of at message end gives a different head order in the scripted round-robin rounds. Protocol-error flits and a single-flit head followed at once by another head check that illegal flits never reach an output and that single-flit messages never leave an output locked.

// File: rtl/flit_pkg.sv
package flit_pkg;
  typedef enum logic [1:0] {
    FT_IDLE = 2'b00,
    FT_HEAD = 2'b01,
    FT_BODY = 2'b10,
    FT_TAIL = 2'b11
  } flit_kind_e;
endpackage

// File: rtl/rr_pick.sv
// Round-robin picker: first request at or after ptr, wrapping.
module rr_pick #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  always_comb begin
    int idx;
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr) + k) % N;
      if (!any && req[idx]) begin
        any      = 1'b1;
        gnt[idx] = 1'b1;
        gnt_idx  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/port_lock.sv
// One output: owner tracking, arbitration pointer and flit mux.
module port_lock
  import flit_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int DATA_W = 8,
  localparam int IW    = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_IN-1:0]        head_req,
  input  logic [N_IN-1:0]        in_valid,
  input  logic [2*N_IN-1:0]      in_type,
  input  logic [N_IN-1:0]        in_last,
  input  logic [N_IN*DATA_W-1:0] in_data,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [1:0]             out_type,
  output logic                   out_last,
  output logic [DATA_W-1:0]      out_data,
  output logic [N_IN-1:0]        head_gnt,
  output logic                   busy,
  output logic [IW-1:0]          owner
);
  logic            busy_q;
  logic [IW-1:0]   owner_q;
  logic [IW-1:0]   ptr_q;
  logic [N_IN-1:0] pick_req;
  logic [N_IN-1:0] pick_gnt;
  logic [IW-1:0]   pick_idx;
  logic            pick_any;
  logic [IW-1:0]   sel;
  logic [1:0]      sel_type;
  logic            xfer;

  function automatic logic [IW-1:0] wrap_next(input logic [IW-1:0] v);
    if (int'(v) == N_IN - 1) return '0;
    return IW'(v + 1'b1);
  endfunction

  assign pick_req = busy_q ? '0 : head_req;

  rr_pick #(.N(N_IN)) u_pick (
    .req    (pick_req),
    .ptr    (ptr_q),
    .gnt    (pick_gnt),
    .gnt_idx(pick_idx),
    .any    (pick_any)
  );

  assign sel      = busy_q ? owner_q : pick_idx;
  assign sel_type = in_type[int'(sel)*2 +: 2];

  assign out_valid = busy_q ? (in_valid[sel] && (sel_type == FT_BODY || sel_type == FT_TAIL))
                            : pick_any;
  assign out_type  = sel_type;
  assign out_last  = in_last[sel];
  assign out_data  = in_data[int'(sel)*DATA_W +: DATA_W];
  assign head_gnt  = pick_gnt;
  assign busy      = busy_q;
  assign owner     = owner_q;
  assign xfer      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (xfer) begin
      if (!busy_q) begin
        if (!out_last) begin
          busy_q  <= 1'b1;
          owner_q <= pick_idx;
        end else begin
          ptr_q <= wrap_next(pick_idx);
        end
      end else if (sel_type == FT_TAIL) begin
        busy_q <= 1'b0;
        ptr_q  <= wrap_next(owner_q);
      end
    end
  end
endmodule

// File: rtl/flit_lock_switch.sv
module flit_lock_switch
  import flit_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_OUT  = 2,
  parameter int DATA_W = 8,
  localparam int IW     = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int DEST_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_IN-1:0]          in_valid,
  input  logic [2*N_IN-1:0]        in_type,
  input  logic [N_IN-1:0]          in_last,
  input  logic [N_IN*DEST_W-1:0]   in_dest,
  input  logic [N_IN*DATA_W-1:0]   in_data,
  output logic [N_IN-1:0]          in_ready,
  output logic [N_OUT-1:0]         out_valid,
  output logic [2*N_OUT-1:0]       out_type,
  output logic [N_OUT-1:0]         out_last,
  output logic [N_OUT*DATA_W-1:0]  out_data,
  input  logic [N_OUT-1:0]         out_ready,
  output logic [N_IN-1:0]          proto_err
);
  logic [N_OUT-1:0]    lk_busy;
  logic [N_OUT*IW-1:0] lk_owner;
  logic [N_IN-1:0]     hreq [N_OUT];
  logic [N_IN-1:0]     hgnt [N_OUT];
  logic [N_IN-1:0]     owns;
  logic [N_IN-1:0]     own_rdy;
  logic [N_IN-1:0]     win_rdy;
  logic [N_IN-1:0]     err_now;
  logic [N_IN-1:0]     err_q;

  always_comb begin
    owns    = '0;
    own_rdy = '0;
    win_rdy = '0;
    for (int i = 0; i < N_IN; i++) begin
      for (int o = 0; o < N_OUT; o++) begin
        if (lk_busy[o] && lk_owner[o*IW +: IW] == IW'(i)) begin
          owns[i]    = 1'b1;
          own_rdy[i] = out_ready[o];
        end
        if (hgnt[o][i] && out_ready[o]) win_rdy[i] = 1'b1;
      end
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    for (genvar i = 0; i < N_IN; i++) begin : g_req
      assign hreq[o][i] = in_valid[i] && in_type[2*i +: 2] == FT_HEAD && !owns[i]
                          && in_dest[i*DEST_W +: DEST_W] == DEST_W'(o);
    end
    port_lock #(.N_IN(N_IN), .DATA_W(DATA_W)) u_lock (
      .clk      (clk),
      .rst      (rst),
      .head_req (hreq[o]),
      .in_valid (in_valid),
      .in_type  (in_type),
      .in_last  (in_last),
      .in_data  (in_data),
      .out_ready(out_ready[o]),
      .out_valid(out_valid[o]),
      .out_type (out_type[2*o +: 2]),
      .out_last (out_last[o]),
      .out_data (out_data[o*DATA_W +: DATA_W]),
      .head_gnt (hgnt[o]),
      .busy     (lk_busy[o]),
      .owner    (lk_owner[o*IW +: IW])
    );
  end

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      err_now[i] = 1'b0;
      unique case (in_type[2*i +: 2])
        FT_IDLE: in_ready[i] = 1'b1;
        FT_HEAD: begin
          in_ready[i] = owns[i] ? 1'b1 : win_rdy[i];
          err_now[i]  = in_valid[i] && owns[i];
        end
        default: begin
          in_ready[i] = owns[i] ? own_rdy[i] : 1'b1;
          err_now[i]  = in_valid[i] && !owns[i];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= err_now;
  end

  assign proto_err = err_q;
endmodule

// File: rtl/flit_lock_chk.sv
module flit_lock_chk
  import flit_pkg::*;
#(
  parameter int N_IN  = 3,
  parameter int N_OUT = 2,
  localparam int IW     = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int DEST_W = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_IN-1:0]        in_valid,
  input logic [N_IN-1:0]        in_ready,
  input logic [2*N_IN-1:0]      in_type,
  input logic [N_IN*DEST_W-1:0] in_dest,
  input logic [N_OUT-1:0]       out_valid,
  input logic [N_OUT-1:0]       out_ready,
  input logic [N_OUT-1:0]       out_last,
  input logic [2*N_OUT-1:0]     out_type,
  input logic [N_OUT-1:0]       busy,
  input logic [N_OUT*IW-1:0]    owner
);
  logic [N_OUT-1:0] own_map [N_IN];

  for (genvar o = 0; o < N_OUT; o++) begin : g_o
    logic [1:0] ot;
    logic       xf;
    assign ot = out_type[2*o +: 2];
    assign xf = out_valid[o] && out_ready[o];

    // R2
    no_head_in_lock_chk: assert property (@(posedge clk) disable iff (rst)
      busy[o] && out_valid[o] |-> ot != FT_HEAD);
    // R2
    owner_kept_chk: assert property (@(posedge clk) disable iff (rst)
      busy[o] && !(xf && ot == FT_TAIL) |=> busy[o] && $stable(owner[o*IW +: IW]));
    // R3
    tail_release_chk: assert property (@(posedge clk) disable iff (rst)
      busy[o] && xf && ot == FT_TAIL |=> !busy[o]);
    // R4
    single_no_lock_chk: assert property (@(posedge clk) disable iff (rst)
      !busy[o] && xf && out_last[o] |=> !busy[o]);

    for (genvar i = 0; i < N_IN; i++) begin : g_i
      assign own_map[i][o] = busy[o] && owner[o*IW +: IW] == IW'(i);
      // R5
      blocked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid[i] && in_type[2*i +: 2] == FT_HEAD && own_map[i] == '0
        && in_dest[i*DEST_W +: DEST_W] == DEST_W'(o) && busy[o]
        && owner[o*IW +: IW] != IW'(i) |-> !in_ready[i]);
      // R7
      stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid[i] && (in_type[2*i +: 2] == FT_BODY || in_type[2*i +: 2] == FT_TAIL)
        && own_map[i][o] && !out_ready[o] |-> !in_ready[i]);
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_one
    // R2
    single_binding_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(own_map[i]) <= 1);
  end
endmodule

bind flit_lock_switch flit_lock_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
  .in_dest(in_dest), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
  .out_type(out_type), .busy(lk_busy), .owner(lk_owner)
);

// File: tb/sim_flit_lock_switch.sv
`timescale 1ns/1ps
module sim_flit_lock_switch;
  localparam int NI = 3;
  localparam int NO = 2;
  localparam int DW = 8;
  localparam logic [1:0] K_IDLE = 2'b00, K_HEAD = 2'b01, K_BODY = 2'b10, K_TAIL = 2'b11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NI-1:0]   in_valid = '0;
  logic [2*NI-1:0] in_type = '0;
  logic [NI-1:0]   in_last = '0;
  logic [NI-1:0]   in_dest = '0;
  logic [NI*DW-1:0] in_data = '0;
  logic [NI-1:0]   in_ready;
  logic [NO-1:0]   out_valid;
  logic [2*NO-1:0] out_type;
  logic [NO-1:0]   out_last;
  logic [NO*DW-1:0] out_data;
  logic [NO-1:0]   out_ready = '1;
  logic [NI-1:0]   proto_err;

  int nchk = 0, nfail = 0;
  int sent [NI];
  int recv [NI];
  logic       mid [NO];
  logic [1:0] cur_src [NO];
  int         exp_seq [NO];
  logic [1:0] hlog [NO][64];
  int         hcnt [NO];

  always #4 clk = ~clk;

  flit_lock_switch #(.N_IN(NI), .N_OUT(NO), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_type(in_type), .in_last(in_last),
    .in_dest(in_dest), .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_type(out_type), .out_last(out_last), .out_data(out_data), .out_ready(out_ready),
    .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input int src, input int d, input int seq);
    return {2'(src), 1'(d), 5'(seq)};
  endfunction

  task automatic set_in(input int i, input logic v, input logic [1:0] t, input logic l,
                        input int d, input int seq);
    in_valid[i]       = v;
    in_type[2*i +: 2] = t;
    in_last[i]        = l;
    in_dest[i]        = 1'(d);
    in_data[i*DW +: DW] = mk(i, d, seq);
  endtask

  task automatic send_msg(input int i, input int d, input int len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      set_in(i, 1'b1, (k == 0) ? K_HEAD : ((k == len-1) ? K_TAIL : K_BODY), len == 1, d, k);
      #3;
      while (!in_ready[i]) begin
        @(negedge clk);
        #3;
      end
      sent[i]++;
    end
    @(negedge clk);
    set_in(i, 1'b0, K_IDLE, 1'b0, 0, 0);
  endtask

  task automatic clear_logs();
    for (int o = 0; o < NO; o++) begin
      hcnt[o] = 0; mid[o] = 1'b0; exp_seq[o] = 0; cur_src[o] = '0;
    end
    for (int i = 0; i < NI; i++) begin
      sent[i] = 0; recv[i] = 0;
    end
  endtask

  // Output monitor: routing, no interleaving, in-order delivery (R1, R2)
  always @(negedge clk) begin
    logic [7:0] dat;
    logic [1:0] kd;
    int src;
    #3;
    if (!rst) begin
      for (int o = 0; o < NO; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          dat = out_data[o*DW +: DW];
          kd  = out_type[2*o +: 2];
          src = int'(dat[7:6]);
          if (src < NI) recv[src]++;
          chk(int'(dat[5]) == o, "R1", "flit on wrong output", int'(dat[5]), o);
          if (kd == K_HEAD) begin
            chk(!mid[o], "R2", "head interleaved into held output", src, int'(cur_src[o]));
            chk(dat[4:0] == 5'd0, "R2", "head sequence", int'(dat[4:0]), 0);
            if (hcnt[o] < 64) hlog[o][hcnt[o]] = dat[7:6];
            hcnt[o]++;
            if (!out_last[o]) begin
              mid[o] = 1'b1; cur_src[o] = dat[7:6]; exp_seq[o] = 1;
            end
          end else begin
            chk(mid[o] && dat[7:6] == cur_src[o], "R2", "body/tail from non-owner", src, int'(cur_src[o]));
            chk(int'(dat[4:0]) == exp_seq[o], "R2", "flit order", int'(dat[4:0]), exp_seq[o]);
            exp_seq[o]++;
            if (kd == K_TAIL) mid[o] = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  task automatic do_reset();
    rst = 1'b1;
    for (int i = 0; i < NI; i++) set_in(i, 1'b0, K_IDLE, 1'b0, 0, 0);
    out_ready = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    clear_logs();
    #3;
    // R9
    chk(out_valid == '0, "R9", "out_valid after reset", int'(out_valid), 0);
    chk(proto_err == '0, "R9", "proto_err after reset", int'(proto_err), 0);
  endtask

  initial begin
    clear_logs();
    do_reset();

    // R11: valid idle flit
    @(negedge clk); set_in(0, 1'b1, K_IDLE, 1'b0, 1, 0); #3;
    chk(in_ready[0], "R11", "idle accepted", int'(in_ready[0]), 1);
    chk(out_valid == '0, "R11", "idle forwarded", int'(out_valid), 0);
    @(negedge clk); set_in(0, 1'b0, K_IDLE, 1'b0, 0, 0); #3;
    chk(out_valid == '0 && proto_err == '0, "R11", "idle side effect", int'(proto_err), 0);

    // R1: same-cycle cut-through
    @(negedge clk); set_in(0, 1'b1, K_HEAD, 1'b0, 1, 0); #3;
    chk(out_valid[1], "R1", "head visible same cycle", int'(out_valid[1]), 1);
    chk(out_data[DW +: DW] == mk(0, 1, 0), "R1", "head data", int'(out_data[DW +: DW]), int'(mk(0, 1, 0)));
    chk(in_ready[0], "R1", "head accepted", int'(in_ready[0]), 1);
    // R5 and R7: competitor blocked, downstream stall
    @(negedge clk);
    set_in(0, 1'b1, K_BODY, 1'b0, 1, 1);
    set_in(1, 1'b1, K_HEAD, 1'b0, 1, 0);
    out_ready[1] = 1'b0;
    #3;
    chk(!in_ready[0], "R7", "owner ready while out_ready low", int'(in_ready[0]), 0);
    chk(!in_ready[1], "R5", "blocked head ready", int'(in_ready[1]), 0);
    chk(out_valid[1] && out_data[DW +: DW] == mk(0, 1, 1), "R2", "owner body shown", int'(out_data[DW +: DW]), int'(mk(0, 1, 1)));
    @(negedge clk); out_ready[1] = 1'b1; #3;
    chk(in_ready[0], "R7", "owner ready after out_ready", int'(in_ready[0]), 1);
    @(negedge clk); set_in(0, 1'b1, K_TAIL, 1'b0, 1, 2); #3;
    chk(!in_ready[1], "R5", "blocked during tail", int'(in_ready[1]), 0);
    @(negedge clk); set_in(0, 1'b0, K_IDLE, 1'b0, 0, 0); #3;
    // R3
    chk(in_ready[1] && out_data[DW +: DW] == mk(1, 1, 0), "R3", "waiting head takes freed output", int'(in_ready[1]), 1);
    @(negedge clk); set_in(1, 1'b1, K_TAIL, 1'b0, 1, 1);
    @(negedge clk); set_in(1, 1'b0, K_IDLE, 1'b0, 0, 0);

    // R4: single-flit message does not lock
    @(negedge clk); set_in(2, 1'b1, K_HEAD, 1'b1, 0, 0); #3;
    chk(in_ready[2], "R4", "single head accepted", int'(in_ready[2]), 1);
    @(negedge clk); set_in(2, 1'b0, K_IDLE, 1'b0, 0, 0); set_in(0, 1'b1, K_HEAD, 1'b1, 0, 0); #3;
    chk(in_ready[0] && out_valid[0], "R4", "next head after single", int'(in_ready[0]), 1);
    @(negedge clk); set_in(0, 1'b0, K_IDLE, 1'b0, 0, 0);

    // R8: body without ownership
    @(negedge clk); set_in(1, 1'b1, K_BODY, 1'b0, 0, 3); #3;
    chk(in_ready[1], "R8", "stray body consumed", int'(in_ready[1]), 1);
    chk(out_valid == '0, "R8", "stray body forwarded", int'(out_valid), 0);
    @(negedge clk); set_in(1, 1'b0, K_IDLE, 1'b0, 0, 0); #3;
    chk(proto_err == 3'b010, "R8", "proto_err for stray body", int'(proto_err), 2);
    // R8: second head from owner
    @(negedge clk); set_in(0, 1'b1, K_HEAD, 1'b0, 0, 0);
    @(negedge clk); set_in(0, 1'b1, K_HEAD, 1'b0, 1, 0); #3;
    chk(in_ready[0] && out_valid == '0, "R8", "second head consumed, not forwarded", int'(out_valid), 0);
    @(negedge clk); set_in(0, 1'b1, K_TAIL, 1'b0, 0, 1); #3;
    chk(proto_err == 3'b001, "R8", "proto_err for second head", int'(proto_err), 1);
    @(negedge clk); set_in(0, 1'b0, K_IDLE, 1'b0, 0, 0); #3;
    chk(proto_err == 3'b000, "R8", "proto_err one cycle", int'(proto_err), 0);

    // R10: two outputs in parallel
    @(negedge clk); set_in(0, 1'b1, K_HEAD, 1'b1, 0, 0); set_in(1, 1'b1, K_HEAD, 1'b1, 1, 0); #3;
    chk(out_valid == 2'b11 && in_ready[1:0] == 2'b11, "R10", "parallel outputs", int'(out_valid), 3);
    @(negedge clk); set_in(0, 1'b0, K_IDLE, 1'b0, 0, 0); set_in(1, 1'b0, K_IDLE, 1'b0, 0, 0);
    repeat (2) @(negedge clk);

    // R6: round-robin order on output 0 from reset
    do_reset();
    fork send_msg(1, 0, 2); send_msg(2, 0, 2); join
    fork send_msg(0, 0, 3); send_msg(1, 0, 2); send_msg(2, 0, 1); join
    send_msg(1, 0, 1);
    fork send_msg(0, 0, 1); send_msg(2, 0, 2); join
    repeat (3) @(negedge clk);
    begin
      int exp_order [8] = '{1, 2, 0, 1, 2, 1, 2, 0};
      chk(hcnt[0] == 8, "R6", "head count", hcnt[0], 8);
      for (int k = 0; k < 8; k++)
        chk(int'(hlog[0][k]) == exp_order[k], "R6", "grant order", int'(hlog[0][k]), exp_order[k]);
    end

    // R2: overlapping message sweep, every input to both outputs
    do_reset();
    fork
      for (int m = 0; m < 24; m++) send_msg(0, m % 2, 1 + (m * 3) % 5);
      for (int m = 0; m < 24; m++) send_msg(1, (m + 1) % 2, 1 + (5 + m * 3) % 5);
      for (int m = 0; m < 24; m++) send_msg(2, (m / 2) % 2, 1 + (10 + m * 2) % 5);
    join
    repeat (4) @(negedge clk);
    for (int i = 0; i < NI; i++)
      chk(recv[i] == sent[i], "R2", "flits delivered per input", recv[i], sent[i]);
    for (int o = 0; o < NO; o++)
      chk(!mid[o], "R3", "output left open", int'(mid[o]), 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule